// File: doc/BRIEF.md
# Virtual Supervisor Timer Compare

This block produces the timer pending bit for a virtualised supervisor. It holds two 64-bit registers: a compare value and a time offset. The guest sees time as the physical time plus the offset, wrapped modulo 2^64. When that guest time is at or past the compare value, a compare term is raised. The pending output is the OR of this compare term and a pending bit injected by the hypervisor.

Software reaches both registers through a simple CSR write port and a combinational read port. In narrow (32-bit) mode each register is split into two 32-bit halves, each at its own address. In wide mode one address carries the whole 64-bit value.

Two feature enables gate the compare term: one from machine level and one from hypervisor level. If either enable is low, only the injected bit drives the output. The pending output is defined at all times and does not depend on whether the hart is running virtualised. Access permission checking and interrupt delivery belong to other blocks.

The CSR port and the enables are control pins. They have no valid/ready handshake: a write takes effect on the clock edge at which `csr_wr` is high, and nothing is ever back-pressured.

Top module: `vstimer_cmp`

## Requirements
- R1: While reset is low, the compare register is forced to all ones, the offset register to zero, and the compare term to zero.
- R2: The compare term is 1 when (time + offset) mod 2^64 >= compare, all unsigned. This includes sums that wrap past 2^64.
- R3: Once the compare value exceeds the guest time, for example after the compare register is rewritten, the compare term returns to 0.
- R4: The compare term after clock edge n is computed from `time_in`, the enables and the register contents present just before edge n-1. A new time is therefore seen at the output two edges later, and a register write three edges after its write edge.
- R5: `vs_pend` = `inject` OR compare term. `inject` reaches `vs_pend` combinationally, with no delay.
- R6: If `m_en` or `h_en` is 0, the compare term is forced to 0, with the same two-edge latency as R4.
- R7: In narrow mode (`half_mode`=1), a write to address 0x24D loads compare bits 31:0 and a write to 0x25D loads compare bits 63:32. Likewise, 0x605 loads offset bits 31:0 and 0x615 loads offset bits 63:32. In each case the data comes from `csr_wdata[31:0]` and the other half is left unchanged.
- R8: In wide mode (`half_mode`=0), a write to 0x24D or 0x605 loads all 64 bits. A write to 0x25D or 0x615 is ignored.
- R9: For a read in narrow mode, the low or high address returns the selected half in `csr_rdata[31:0]`, with bits 63:32 set to zero. For a read in wide mode, the low address returns all 64 bits and the high address returns zero. Any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_in | input | 64 | Physical time value |
| m_en | input | 1 | Machine-level feature enable |
| h_en | input | 1 | Hypervisor-level feature enable |
| inject | input | 1 | Hypervisor-injected pending bit |
| half_mode | input | 1 | 1 selects 32-bit half access |
| csr_wr | input | 1 | Write strobe |
| csr_addr | input | 12 | Write address |
| csr_wdata | input | 64 | Write data |
| csr_raddr | input | 12 | Read address |
| csr_rdata | output | 64 | Read data (combinational) |
| vs_pend | output | 1 | Virtual supervisor timer pending |

## Verification
A corrupted compare or offset register shows up in two places. It can be read back directly on the CSR read port in the same cycle. It also flips `vs_pend` three edges after the write, at the first time value that straddles the bad threshold. A wrong pipeline stage, such as a stale sum or a lost enable, shows on `vs_pend` exactly two edges after the input that should have moved it. The reference model is compared on every cycle, so a single-cycle early or late transition is caught. The wrap case is exercised with an offset near 2^64, so an adder that saturates or carries into a 65th bit would change `vs_pend` where the model does not.

// File: rtl/vtc_pkg.sv
package vtc_pkg;
  // Per-register write action decoded from the CSR port.
  typedef enum logic [1:0] {
    WSEL_NONE = 2'd0,
    WSEL_LO   = 2'd1,
    WSEL_HI   = 2'd2,
    WSEL_FULL = 2'd3
  } wsel_e;
endpackage

// File: rtl/vtc_split_reg.sv
module vtc_split_reg
  import vtc_pkg::*;
#(
  parameter int           TW      = 64,
  parameter int           AW      = 12,
  parameter logic [AW-1:0] LO_ADDR = '0,
  parameter logic [AW-1:0] HI_ADDR = '0,
  parameter logic [TW-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          half_mode,
  input  logic          wr,
  input  logic [AW-1:0] waddr,
  input  logic [TW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [TW-1:0] q,
  output logic [TW-1:0] rdata
);
  localparam int HW = TW / 2;

  wsel_e sel;

  always_comb begin
    sel = WSEL_NONE;
    if (wr) begin
      if (waddr == LO_ADDR)                sel = half_mode ? WSEL_LO : WSEL_FULL;
      else if (waddr == HI_ADDR && half_mode) sel = WSEL_HI;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST_VAL;
    end else begin
      case (sel)
        WSEL_LO:   q[HW-1:0]  <= wdata[HW-1:0];
        WSEL_HI:   q[TW-1:HW] <= wdata[HW-1:0];
        WSEL_FULL: q          <= wdata;
        default:   q          <= q;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    if (raddr == LO_ADDR) begin
      if (half_mode) rdata = {{(TW-HW){1'b0}}, q[HW-1:0]};
      else           rdata = q;
    end else if (raddr == HI_ADDR && half_mode) begin
      rdata = {{(TW-HW){1'b0}}, q[TW-1:HW]};
    end
  end
endmodule

// File: rtl/vtc_cmp_pipe.sv
module vtc_cmp_pipe #(
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] phys_time,
  input  logic [TW-1:0] offset,
  input  logic [TW-1:0] cmp,
  input  logic          en,
  output logic          term
);
  logic [TW-1:0] sum_q;
  logic [TW-1:0] cmp_q;
  logic          en_q;

  // Stage 1: wrapping add, with compare value and enable aligned to it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      cmp_q <= '1;
      en_q  <= 1'b0;
    end else begin
      sum_q <= phys_time + offset;
      cmp_q <= cmp;
      en_q  <= en;
    end
  end

  // Stage 2: unsigned magnitude compare.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) term <= 1'b0;
    else        term <= en_q && (sum_q >= cmp_q);
  end
endmodule

// File: rtl/vstimer_cmp.sv
module vstimer_cmp #(
  parameter int            TW      = 64,
  parameter int            AW      = 12,
  parameter logic [AW-1:0] CMP_LO  = 12'h24D,
  parameter logic [AW-1:0] CMP_HI  = 12'h25D,
  parameter logic [AW-1:0] OFF_LO  = 12'h605,
  parameter logic [AW-1:0] OFF_HI  = 12'h615
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] time_in,
  input  logic          m_en,
  input  logic          h_en,
  input  logic          inject,
  input  logic          half_mode,
  input  logic          csr_wr,
  input  logic [AW-1:0] csr_addr,
  input  logic [TW-1:0] csr_wdata,
  input  logic [AW-1:0] csr_raddr,
  output logic [TW-1:0] csr_rdata,
  output logic          vs_pend
);
  logic [TW-1:0] cmp_val, off_val;
  logic [TW-1:0] cmp_rd, off_rd;
  logic          cmp_term;

  vtc_split_reg #(
    .TW(TW), .AW(AW), .LO_ADDR(CMP_LO), .HI_ADDR(CMP_HI), .RST_VAL({TW{1'b1}})
  ) u_cmp_reg (
    .clk(clk), .rst_n(rst_n), .half_mode(half_mode), .wr(csr_wr),
    .waddr(csr_addr), .wdata(csr_wdata), .raddr(csr_raddr),
    .q(cmp_val), .rdata(cmp_rd)
  );

  vtc_split_reg #(
    .TW(TW), .AW(AW), .LO_ADDR(OFF_LO), .HI_ADDR(OFF_HI), .RST_VAL({TW{1'b0}})
  ) u_off_reg (
    .clk(clk), .rst_n(rst_n), .half_mode(half_mode), .wr(csr_wr),
    .waddr(csr_addr), .wdata(csr_wdata), .raddr(csr_raddr),
    .q(off_val), .rdata(off_rd)
  );

  vtc_cmp_pipe #(.TW(TW)) u_pipe (
    .clk(clk), .rst_n(rst_n), .phys_time(time_in), .offset(off_val),
    .cmp(cmp_val), .en(m_en & h_en), .term(cmp_term)
  );

  // Address ranges are disjoint, so a plain OR merges the two read ports.
  assign csr_rdata = cmp_rd | off_rd;
  assign vs_pend   = inject | cmp_term;
endmodule

// File: rtl/vstimer_cmp_chk.sv
module vstimer_cmp_chk #(
  parameter int            TW     = 64,
  parameter int            AW     = 12,
  parameter logic [AW-1:0] CMP_LO = 12'h24D,
  parameter logic [AW-1:0] CMP_HI = 12'h25D
) (
  input logic          clk,
  input logic          rst_n,
  input logic          m_en,
  input logic          h_en,
  input logic          inject,
  input logic          half_mode,
  input logic          csr_wr,
  input logic [AW-1:0] csr_addr,
  input logic [TW-1:0] csr_wdata,
  input logic [TW-1:0] cmp_val,
  input logic          vs_pend
);
  localparam int HW = TW / 2;

  AST_INJECT_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    inject |-> vs_pend); // R5

  AST_MASKED_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    (!inject && $past(!(m_en && h_en), 2)) |-> !vs_pend); // R6

  AST_HALF_LO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && half_mode && csr_addr == CMP_LO)
      |=> cmp_val[HW-1:0] == $past(csr_wdata[HW-1:0])); // R7

  AST_FULL_LO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && !half_mode && csr_addr == CMP_LO)
      |=> cmp_val == $past(csr_wdata)); // R8

  AST_FULL_HI_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && !half_mode && csr_addr == CMP_HI) |=> $stable(cmp_val)); // R8
endmodule

bind vstimer_cmp vstimer_cmp_chk #(
  .TW(TW), .AW(AW), .CMP_LO(CMP_LO), .CMP_HI(CMP_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .m_en(m_en), .h_en(h_en), .inject(inject),
  .half_mode(half_mode), .csr_wr(csr_wr), .csr_addr(csr_addr),
  .csr_wdata(csr_wdata), .cmp_val(cmp_val), .vs_pend(vs_pend)
);

// File: tb/vstimer_cmp_bench.sv
module vstimer_cmp_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] time_in = '0;
  logic        m_en = 1'b0, h_en = 1'b0, inject = 1'b0, half_mode = 1'b0;
  logic        csr_wr = 1'b0;
  logic [11:0] csr_addr = '0, csr_raddr = '0;
  logic [63:0] csr_wdata = '0;
  logic [63:0] csr_rdata;
  logic        vs_pend;

  int checks = 0, errors = 0;
  bit done = 0;
  string phase = "R1";

  // Reference model state
  logic [63:0] cmp_m, off_m, guest;
  logic        stage_m = 1'b0, term_m = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  vstimer_cmp u_vstimer_cmp (
    .clk(clk), .rst_n(rst_n), .time_in(time_in), .m_en(m_en), .h_en(h_en),
    .inject(inject), .half_mode(half_mode), .csr_wr(csr_wr), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_raddr(csr_raddr), .csr_rdata(csr_rdata),
    .vs_pend(vs_pend)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      cmp_m = '1; off_m = '0; stage_m = 1'b0; term_m = 1'b0;
    end else begin
      term_m  = stage_m;
      guest   = time_in + off_m;
      stage_m = m_en && h_en && (guest >= cmp_m);
      if (csr_wr) begin
        if (csr_addr == 12'h24D) begin
          if (half_mode) cmp_m[31:0] = csr_wdata[31:0]; else cmp_m = csr_wdata;
        end
        if (csr_addr == 12'h25D && half_mode) cmp_m[63:32] = csr_wdata[31:0];
        if (csr_addr == 12'h605) begin
          if (half_mode) off_m[31:0] = csr_wdata[31:0]; else off_m = csr_wdata;
        end
        if (csr_addr == 12'h615 && half_mode) off_m[63:32] = csr_wdata[31:0];
      end
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (!done) begin
      checks++;
      if (vs_pend !== (inject | term_m)) begin
        errors++;
        $display("FAIL %s cycle pend: actual %0b expected %0b", phase, vs_pend, inject | term_m);
      end
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d, input logic half);
    half_mode = half; csr_addr = a; csr_wdata = d; csr_wr = 1'b1;
    step();
    csr_wr = 1'b0;
  endtask

  task automatic chk_rd(input string tag, input logic [11:0] a, input logic [63:0] exp);
    csr_raddr = a; #2;
    checks++;
    if (csr_rdata !== exp) begin
      errors++;
      $display("FAIL %s read %h: actual %h expected %h", tag, a, csr_rdata, exp);
    end
  endtask

  task automatic chk_pend(input string tag, input logic exp);
    #2;
    checks++;
    if (vs_pend !== exp) begin
      errors++;
      $display("FAIL %s pend: actual %0b expected %0b", tag, vs_pend, exp);
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset values
    step(3);
    chk_pend("R1", 1'b0);
    chk_rd("R1", 12'h24D, 64'hFFFF_FFFF_FFFF_FFFF);
    chk_rd("R1", 12'h605, 64'h0);
    rst_n = 1'b1; m_en = 1'b1; h_en = 1'b1;
    step();

    // R2/R4: basic compare and latency
    phase = "R2"; time_in = 64'd100;
    wr(12'h24D, 64'd200, 1'b0);
    step(3);
    chk_pend("R2", 1'b0);
    phase = "R4"; time_in = 64'd200;
    step(); chk_pend("R4", 1'b0);
    step(); chk_pend("R4", 1'b1);

    // R3: rewrite compare above guest time
    phase = "R3";
    wr(12'h24D, 64'd500, 1'b0);
    chk_pend("R3", 1'b1);
    step(2); chk_pend("R3", 1'b0);

    // R7: half writes of offset; R2 wrap
    phase = "R7";
    wr(12'h605, 64'hFFFF_FF9C, 1'b1);
    wr(12'h615, 64'hFFFF_FFFF, 1'b1);
    chk_rd("R7", 12'h605, 64'hFFFF_FF9C);
    chk_rd("R7", 12'h615, 64'hFFFF_FFFF);
    phase = "R2"; time_in = 64'd150; step(3);
    chk_pend("R2", 1'b0);
    wr(12'h24D, 64'd40, 1'b1); step(3);
    chk_pend("R2", 1'b1);
    time_in = 64'd50; step(3); chk_pend("R2", 1'b1);
    wr(12'h25D, 64'hFFFF_FFFF, 1'b1);
    wr(12'h24D, 64'hFFFF_FFF6, 1'b1);
    chk_rd("R7", 12'h25D, 64'hFFFF_FFFF);
    step(3); chk_pend("R2", 1'b0);
    time_in = 64'd95; step(3); chk_pend("R2", 1'b1);
    time_in = 64'd100; step(3); chk_pend("R2", 1'b0);

    // R6: enable masking, R5: injection
    phase = "R6"; time_in = 64'd95; step(3);
    m_en = 1'b0; step(); chk_pend("R6", 1'b1);
    step(); chk_pend("R6", 1'b0);
    phase = "R5"; inject = 1'b1; chk_pend("R5", 1'b1);
    step(); inject = 1'b0; chk_pend("R5", 1'b0);
    m_en = 1'b1; h_en = 1'b0; phase = "R6"; step(3); chk_pend("R6", 1'b0);
    h_en = 1'b1; step(3); chk_pend("R6", 1'b1);

    // R8: wide-mode high address ignored
    phase = "R8";
    wr(12'h24D, 64'h1234_5678_9ABC_DEF0, 1'b0);
    wr(12'h25D, 64'h0, 1'b0);
    wr(12'h615, 64'h0, 1'b0);
    chk_rd("R8", 12'h24D, 64'h1234_5678_9ABC_DEF0);
    chk_rd("R8", 12'h605, 64'hFFFF_FFFF_FFFF_FF9C);

    // R9: read mapping
    phase = "R9";
    chk_rd("R9", 12'h25D, 64'h0);
    half_mode = 1'b1;
    chk_rd("R9", 12'h25D, 64'h1234_5678);
    chk_rd("R9", 12'h24D, 64'h9ABC_DEF0);
    chk_rd("R9", 12'h123, 64'h0);
    step(4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule